// File: doc/BRIEF.md
# Masked Video-Controller Register Bank

This block holds the 32-bit configuration registers of a video controller behind a simple word-addressed write port and read port. A write to a configuration register keeps only the bits that are defined for that register. The stored values are presented on a flat output bus so that the display and rendering engines can use them directly. A window of table words stores the written data unchanged. A small set of identification and position locations reads as constants and ignores writes.

Two locations are commands. They store nothing and produce a single-cycle pulse only when the written value meets a condition. A write to the primary display base address also raises a pulse, so that a frame that is waiting to be presented can be released. One read location returns a live beam status word that alternates with a free-running cycle counter. Reads are registered and return their data one cycle after the request.

Top module: `vreg_bank`

## Requirements
- R1: After synchronous reset every configuration register, every table word, `rd_data`, `rd_vld` and all three pulse outputs are 0.
- R2: A write to a configuration register stores `wr_data` ANDed with that register's mask. Register offsets and masks: 0x008 reset control 0x00000007, 0x020 primary display base 0x00FFFFFC, 0x024 secondary display base 0x00FFFFFC, 0x028 display size 0x3FFFFFFF, 0x02C display mode 0x00FFFF7F, 0x030 border colour 0x01FFFFFF, 0x034 display config 0x000003FF, 0x040 horizontal clip 0x07FF07FF, 0x044 vertical clip 0x03FF03FF, 0x048 far clip 0xFFFFFFF0, 0x04C tile base 0x00FFFFE0, 0x050 list base 0x00FFFFE0, 0x054 tile config 0x00133333. Register k occupies bits 32k+31:32k of `cfg_flat`, with k counted in the order listed here, starting at 0.
- R3: Aligned offsets from 0x200 through 0x5FC are table words that store `wr_data` unmasked and read back. 0x1FC and 0x600 lie outside the table.
- R4: Offsets 0x000 (identity), 0x004 (version), 0x060 (gun position), 0x064 and 0x068 (list positions) are read-only. Writes to them change nothing. They read `ID_VALUE`, `VER_VALUE`, 0, 0 and 0.
- R5: A write of exactly 0xFFFFFFFF to 0x010 raises `render_go` for one cycle, in the cycle after the write. Any other value raises nothing. The location stores nothing and reads 0.
- R6: A write to 0x014 with bit 31 set raises `list_init` for one cycle, in the cycle after the write. A write with bit 31 clear raises nothing. The location reads 0.
- R7: Every write to 0x020 raises `base_written` for one cycle after the write. A write to the secondary base at 0x024 does not.
- R8: A read of 0x070 returns 0x00002000 when bit `BEAM_BIT` of a cycle counter is 1, and 0x00000001 when it is 0. The counter is cleared by reset and counts every clock.
- R9: Writes to unmapped or unaligned offsets are dropped. Reads of them return 0.
- R10: `rd_data` and `rd_vld` are valid in the cycle after `rd_en`. A read and a write to the same location in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Read data, one cycle after request |
| rd_vld | output | 1 | Read data valid |
| cfg_flat | output | 416 | All configuration registers, register k at bits 32k+31:32k |
| render_go | output | 1 | Render command pulse |
| list_init | output | 1 | List processor init pulse |
| base_written | output | 1 | Primary display base written pulse |

## Verification
A wrong mask or a misdecoded offset appears on `cfg_flat` in the cycle right after the write, and on `rd_data` one cycle after the next read of that location. A command decoder in the wrong state shows as a pulse that is missing or present in that same following cycle. A counter with the wrong phase shows when the beam word flips at the wrong read. Randomised writes mixed across all location classes are each followed at once by a pulse check and a readback. Any disagreement is therefore found within two cycles of its cause.

// File: rtl/vreg_pkg.sv
package vreg_pkg;

    localparam int AW         = 12;
    localparam int DW         = 32;
    localparam int NUM_STORED = 13;
    localparam int SIDX_W     = $clog2(NUM_STORED);
    localparam logic [AW-1:0] TBL_LO = 12'h200;
    localparam logic [AW-1:0] TBL_HI = 12'h600;
    localparam int TBL_DEPTH  = (int'(TBL_HI) - int'(TBL_LO)) / 4;
    localparam int TIDX_W     = $clog2(TBL_DEPTH);

    localparam logic [AW-1:0] OFF_ID    = 12'h000;
    localparam logic [AW-1:0] OFF_VER   = 12'h004;
    localparam logic [AW-1:0] OFF_GO    = 12'h010;
    localparam logic [AW-1:0] OFF_INIT  = 12'h014;
    localparam logic [AW-1:0] OFF_GUN   = 12'h060;
    localparam logic [AW-1:0] OFF_LPA   = 12'h064;
    localparam logic [AW-1:0] OFF_LPB   = 12'h068;
    localparam logic [AW-1:0] OFF_BEAM  = 12'h070;
    localparam logic [AW-1:0] OFF_BASEA = 12'h020;
    localparam logic [SIDX_W-1:0] IDX_BASEA = 4'd1;

    typedef enum logic [2:0] {
        K_NONE, K_RO, K_STORE, K_TABLE, K_GO, K_INIT, K_BEAM
    } kind_e;

    typedef struct packed {
        kind_e               kind;
        logic [SIDX_W-1:0]   sidx;
        logic [TIDX_W-1:0]   tidx;
        logic [DW-1:0]       mask;
    } dec_t;

    function automatic logic [AW-1:0] stored_off(input int i);
        case (i)
            0:  return 12'h008;
            1:  return 12'h020;
            2:  return 12'h024;
            3:  return 12'h028;
            4:  return 12'h02C;
            5:  return 12'h030;
            6:  return 12'h034;
            7:  return 12'h040;
            8:  return 12'h044;
            9:  return 12'h048;
            10: return 12'h04C;
            11: return 12'h050;
            default: return 12'h054;
        endcase
    endfunction

    function automatic logic [DW-1:0] stored_mask(input int i);
        case (i)
            0:  return 32'h0000_0007;
            1:  return 32'h00FF_FFFC;
            2:  return 32'h00FF_FFFC;
            3:  return 32'h3FFF_FFFF;
            4:  return 32'h00FF_FF7F;
            5:  return 32'h01FF_FFFF;
            6:  return 32'h0000_03FF;
            7:  return 32'h07FF_07FF;
            8:  return 32'h03FF_03FF;
            9:  return 32'hFFFF_FFF0;
            10: return 32'h00FF_FFE0;
            11: return 32'h00FF_FFE0;
            default: return 32'h0013_3333;
        endcase
    endfunction

    function automatic dec_t decode_addr(input logic [AW-1:0] a);
        dec_t d;
        logic [AW-1:0] rel;
        d      = '0;
        d.kind = K_NONE;
        rel    = a - TBL_LO;
        if (a[1:0] == 2'b00) begin
            if (a >= TBL_LO && a < TBL_HI) begin
                d.kind = K_TABLE;
                d.tidx = rel[TIDX_W+1:2];
            end else begin
                for (int i = 0; i < NUM_STORED; i++) begin
                    if (a == stored_off(i)) begin
                        d.kind = K_STORE;
                        d.sidx = SIDX_W'(i);
                        d.mask = stored_mask(i);
                    end
                end
                case (a)
                    OFF_ID, OFF_VER, OFF_GUN, OFF_LPA, OFF_LPB: d.kind = K_RO;
                    OFF_GO:   d.kind = K_GO;
                    OFF_INIT: d.kind = K_INIT;
                    OFF_BEAM: d.kind = K_BEAM;
                    default: ;
                endcase
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/vreg_decode.sv
module vreg_decode
    import vreg_pkg::*;
(
    input  logic [AW-1:0] addr,
    output dec_t          dec
);
    always_comb dec = decode_addr(addr);
endmodule

// File: rtl/vreg_beam.sv
module vreg_beam #(
    parameter int BEAM_BIT = 5
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] status
);
    localparam int CW = BEAM_BIT + 1;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign status = cnt_q[BEAM_BIT] ? 32'h0000_2000 : 32'h0000_0001;

    p_beam_count_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cnt_q == CW'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/vreg_store.sv
module vreg_store
    import vreg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  dec_t                     wdec,
    input  logic [DW-1:0]            wdata,
    input  logic [TIDX_W-1:0]        tbl_ridx,
    output logic [DW-1:0]            tbl_rdata,
    output logic [NUM_STORED*DW-1:0] cfg_flat
);
    logic [DW-1:0] cfg_q [NUM_STORED];
    logic [DW-1:0] tbl_q [TBL_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_STORED; i++) cfg_q[i] <= '0;
            for (int j = 0; j < TBL_DEPTH; j++)  tbl_q[j] <= '0;
        end else if (we) begin
            if (wdec.kind == K_STORE && int'(wdec.sidx) < NUM_STORED)
                cfg_q[wdec.sidx] <= wdata & wdec.mask;
            if (wdec.kind == K_TABLE)
                tbl_q[wdec.tidx] <= wdata;
        end
    end

    assign tbl_rdata = tbl_q[tbl_ridx];

    for (genvar g = 0; g < NUM_STORED; g++) begin : g_out
        assign cfg_flat[g*DW +: DW] = cfg_q[g];
        p_mask_r2: assert property (@(posedge clk) disable iff (rst)
            (cfg_q[g] & ~stored_mask(g)) == '0);
    end
endmodule

// File: rtl/vreg_bank.sv
module vreg_bank
    import vreg_pkg::*;
#(
    parameter logic [31:0] ID_VALUE  = 32'h5A17_0C01,
    parameter logic [31:0] VER_VALUE = 32'h0000_0011,
    parameter int          BEAM_BIT  = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [11:0]                   wr_addr,
    input  logic [31:0]                   wr_data,
    input  logic                          rd_en,
    input  logic [11:0]                   rd_addr,
    output logic [31:0]                   rd_data,
    output logic                          rd_vld,
    output logic [NUM_STORED*32-1:0]      cfg_flat,
    output logic                          render_go,
    output logic                          list_init,
    output logic                          base_written
);
    dec_t          wdec, rdec;
    logic [DW-1:0] tbl_rdata, beam_word, cfg_sel;

    vreg_decode u_wdec (.addr(wr_addr), .dec(wdec));
    vreg_decode u_rdec (.addr(rd_addr), .dec(rdec));

    vreg_store u_store (
        .clk(clk), .rst(rst), .we(wr_en), .wdec(wdec), .wdata(wr_data),
        .tbl_ridx(rdec.tidx), .tbl_rdata(tbl_rdata), .cfg_flat(cfg_flat)
    );

    vreg_beam #(.BEAM_BIT(BEAM_BIT)) u_beam (
        .clk(clk), .rst(rst), .status(beam_word)
    );

    always_comb begin
        cfg_sel = '0;
        for (int i = 0; i < NUM_STORED; i++)
            if (rdec.sidx == SIDX_W'(i)) cfg_sel = cfg_flat[i*DW +: DW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data      <= '0;
            rd_vld       <= 1'b0;
            render_go    <= 1'b0;
            list_init    <= 1'b0;
            base_written <= 1'b0;
        end else begin
            rd_vld       <= rd_en;
            render_go    <= wr_en && wdec.kind == K_GO && (&wr_data);
            list_init    <= wr_en && wdec.kind == K_INIT && wr_data[31];
            base_written <= wr_en && wdec.kind == K_STORE && wdec.sidx == IDX_BASEA;
            if (rd_en) begin
                case (rdec.kind)
                    K_STORE: rd_data <= cfg_sel & rdec.mask;
                    K_TABLE: rd_data <= tbl_rdata;
                    K_BEAM:  rd_data <= beam_word;
                    K_RO:    rd_data <= (rd_addr == OFF_ID)  ? ID_VALUE :
                                        (rd_addr == OFF_VER) ? VER_VALUE : '0;
                    default: rd_data <= '0;
                endcase
            end
        end
    end

    p_go_cause_r5: assert property (@(posedge clk) disable iff (rst)
        render_go |-> $past(wr_en && wr_addr == OFF_GO && wr_data == 32'hFFFF_FFFF));
    p_init_cause_r6: assert property (@(posedge clk) disable iff (rst)
        list_init |-> $past(wr_en && wr_addr == OFF_INIT && wr_data[31]));
    p_base_cause_r7: assert property (@(posedge clk) disable iff (rst)
        base_written |-> $past(wr_en && wr_addr == OFF_BASEA));
    p_ro_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == OFF_ID || wr_addr == OFF_GUN || wr_addr == OFF_LPB))
        |=> $stable(cfg_flat));
    p_vld_r10: assert property (@(posedge clk) disable iff (rst)
        rd_vld |-> $past(rd_en));
    p_beam_word_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_vld && $past(rd_addr) == OFF_BEAM) |->
        (rd_data == 32'h0000_2000 || rd_data == 32'h0000_0001));
endmodule

// File: tb/vreg_bank_bench.sv
`timescale 1ns/1ps
module vreg_bank_bench;
    localparam logic [31:0] IDV = 32'h5A17_0C01;
    localparam logic [31:0] VRV = 32'h0000_0011;
    localparam int BB = 5;
    localparam int NS = 13;

    logic clk = 1'b0, rst = 1'b1;
    logic wr_en = 0, rd_en = 0;
    logic [11:0] wr_addr = 0, rd_addr = 0;
    logic [31:0] wr_data = 0, rd_data;
    logic rd_vld, render_go, list_init, base_written;
    logic [NS*32-1:0] cfg_flat;

    int nchk = 0, nerr = 0, edges = 0;
    logic [31:0] model [0:1023];
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) if (rst) edges <= 0; else edges <= edges + 1;

    vreg_bank #(.ID_VALUE(IDV), .VER_VALUE(VRV), .BEAM_BIT(BB)) u_vreg_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_vld(rd_vld),
        .cfg_flat(cfg_flat), .render_go(render_go), .list_init(list_init),
        .base_written(base_written));

    function automatic logic [11:0] b_off(int i);
        logic [11:0] t [13] = '{12'h008,12'h020,12'h024,12'h028,12'h02C,12'h030,
                                12'h034,12'h040,12'h044,12'h048,12'h04C,12'h050,12'h054};
        return t[i];
    endfunction
    function automatic logic [32:0] b_mask(logic [11:0] a);
        case (a)
            12'h008: return {1'b1, 32'h0000_0007};
            12'h020, 12'h024: return {1'b1, 32'h00FF_FFFC};
            12'h028: return {1'b1, 32'h3FFF_FFFF};
            12'h02C: return {1'b1, 32'h00FF_FF7F};
            12'h030: return {1'b1, 32'h01FF_FFFF};
            12'h034: return {1'b1, 32'h0000_03FF};
            12'h040: return {1'b1, 32'h07FF_07FF};
            12'h044: return {1'b1, 32'h03FF_03FF};
            12'h048: return {1'b1, 32'hFFFF_FFF0};
            12'h04C, 12'h050: return {1'b1, 32'h00FF_FFE0};
            12'h054: return {1'b1, 32'h0013_3333};
            default: return '0;
        endcase
    endfunction
    function automatic logic [31:0] exp_read(logic [11:0] a, int e);
        if (a == 12'h000) return IDV;
        if (a == 12'h004) return VRV;
        if (a == 12'h070) return ((e >> BB) & 1) != 0 ? 32'h2000 : 32'h1;
        return model[a[11:2]];
    endfunction
    function automatic void model_write(logic [11:0] a, logic [31:0] d);
        logic [32:0] m = b_mask(a);
        if (a[1:0] != 0) return;
        if (m[32]) model[a[11:2]] = d & m[31:0];
        else if (a >= 12'h200 && a < 12'h600) model[a[11:2]] = d;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [11:0] a, logic [31:0] d, string req);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
        model_write(a, d);
        chk({req, " R5 go"},   {31'b0, render_go},    {31'b0, a == 12'h010 && d == 32'hFFFF_FFFF});
        chk({req, " R6 init"}, {31'b0, list_init},    {31'b0, a == 12'h014 && d[31]});
        chk({req, " R7 base"}, {31'b0, base_written}, {31'b0, a == 12'h020});
    endtask

    task automatic do_read(logic [11:0] a, string req);
        int e;
        @(negedge clk); rd_en = 1; rd_addr = a; e = edges;
        @(negedge clk); rd_en = 0;
        chk({req, " R10 vld"}, {31'b0, rd_vld}, 32'd1);
        chk(req, rd_data, exp_read(a, e));
    endtask

    task automatic chk_cfg(string req);
        for (int i = 0; i < NS; i++)
            chk(req, cfg_flat[i*32 +: 32], model[b_off(i) >> 2]);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) model[i] = '0;
        void'($urandom(32'h1D5EED));
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        chk("R1 go", {31'b0, render_go}, 0);
        chk("R1 init", {31'b0, list_init}, 0);
        chk("R1 base", {31'b0, base_written}, 0);
        chk("R1 vld", {31'b0, rd_vld}, 0);
        chk_cfg("R1 cfg");
        do_read(12'h200, "R1 table");
        // R2 directed full-ones writes expose each mask
        for (int i = 0; i < NS; i++) do_write(b_off(i), 32'hFFFF_FFFF, "R2");
        chk_cfg("R2 mask");
        for (int i = 0; i < NS; i++) do_read(b_off(i), "R2 readback");
        // R3 table boundaries
        do_write(12'h200, 32'hCAFE_F00D, "R3"); do_read(12'h200, "R3 low");
        do_write(12'h5FC, 32'h1234_5678, "R3"); do_read(12'h5FC, "R3 high");
        do_write(12'h1FC, 32'hDEAD_BEEF, "R9"); do_read(12'h1FC, "R3 below");
        do_write(12'h600, 32'hDEAD_BEEF, "R9"); do_read(12'h600, "R3 above");
        // R4 read-only
        for (int k = 0; k < 5; k++) begin
            logic [11:0] ro [5] = '{12'h000, 12'h004, 12'h060, 12'h064, 12'h068};
            do_write(ro[k], 32'hFFFF_FFFF, "R4");
            do_read(ro[k], "R4 ro");
        end
        chk_cfg("R4 cfg");
        // R5 / R6 command values
        do_write(12'h010, 32'hFFFF_FFFE, "R5 near"); do_write(12'h010, 32'hFFFF_FFFF, "R5 exact");
        do_read(12'h010, "R5 reads0");
        do_write(12'h014, 32'h7FFF_FFFF, "R6 clr"); do_write(12'h014, 32'h8000_0000, "R6 set");
        do_read(12'h014, "R6 reads0");
        // R7 secondary base does not pulse
        do_write(12'h024, 32'h0012_3454, "R7 second");
        // R9 unaligned and unmapped
        do_write(12'h022, 32'h0000_0000, "R9"); do_read(12'h020, "R9 unaligned");
        do_write(12'h0F0, 32'h5555_AAAA, "R9"); do_read(12'h0F0, "R9 unmapped");
        // R8 beam across counter bit toggles
        for (int k = 0; k < 70; k++) do_read(12'h070, "R8 beam");
        // R10 read and write same location in one cycle
        @(negedge clk); wr_en = 1; wr_addr = 12'h030; wr_data = 32'h0ABC_DEF0;
        rd_en = 1; rd_addr = 12'h030;
        @(negedge clk); wr_en = 0; rd_en = 0;
        chk("R10 old", rd_data, model[12'h030 >> 2]);
        model_write(12'h030, 32'h0ABC_DEF0);
        do_read(12'h030, "R10 new");
        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [11:0] a;
            logic [31:0] d = $urandom;
            case ($urandom % 6)
                0, 1: a = b_off(int'($urandom % NS));
                2:    a = 12'h200 + 12'(($urandom % 256) * 4);
                3:    a = 12'(($urandom % 1024) * 4);
                4:    begin a = 12'h010; if ($urandom % 2 == 0) d = 32'hFFFF_FFFF; end
                default: a = 12'h014;
            endcase
            do_write(a, d, "R2 R3 R9 rand");
            do_read(a, "R2 R3 R9 rand");
        end
        chk_cfg("R2 final");
        done = 1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule